// File: doc/BRIEF.md
# Split Read Request Decomposer

This block sits on the downstream path of a bridge and shapes memory read requests before they are issued as split transactions. Each accepted request carries a start address and a 12-bit byte count. A 32-bit configuration word decides what happens to the request. Its upper half is a writable commitment limit, counted in 128-byte units. Its lower half is a fixed, read-only buffer capacity.

The limit is sampled in the cycle a request is accepted. If the limit is below the full-forward threshold, the request goes out as a series of sub-requests of at most 512 bytes each, with the address advancing by the size of each piece. Otherwise the whole byte count goes out as one sub-request. Sub-requests leave through a valid/ready port. The block accepts no new request until the last piece of the current one has been taken.

Top module: `split_read_decomposer`

## Requirements
- R1: After reset the configuration word reads 0x0020_0020. Bits 31:16 hold the limit and bits 15:0 always read 0x0020, which is 32 units of 128 bytes.
- R2: A write sets bits 31:16 to the written bits 31:16. Written bits 15:0 have no effect, and the read value is available the cycle after the write.
- R3: If the limit at acceptance is below 0x0100, every sub-request is at most 512 bytes. A request larger than 512 bytes is cut into 512-byte pieces, and the final piece carries the remainder.
- R4: If the limit at acceptance is 0x0100 or above, exactly one sub-request is issued, and it carries the whole byte count.
- R5: The first sub-request has the request address. Each later one has the previous address plus the previous size. The sizes add up to the original count.
- R6: A byte count field of 0 means 4096 bytes, on both input and output. A request of 512 bytes or less gives a single sub-request in either mode.
- R7: A limit write made while a request is being split does not change that request. It governs only requests accepted afterwards.
- R8: While a sub-request is valid and not ready, its address, count and last flag stay unchanged. req_ready_o is low while sub-requests are pending. sub_last_o marks the final piece.
- R9: During reset and right after it, sub_valid_o is low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data: limit in 31:16, capacity in 15:0 |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Request start address |
| req_bcnt_i | input | 12 | Request byte count, 0 means 4096 |
| sub_valid_o | output | 1 | Sub-request valid |
| sub_ready_i | input | 1 | Downstream takes the sub-request |
| sub_addr_o | output | ADDR_W | Sub-request address |
| sub_bcnt_o | output | 12 | Sub-request byte count, 0 means 4096 |
| sub_last_o | output | 1 | Final sub-request of the current request |

## Verification
The hardest case to reach from the ports is a limit rewrite that lands between two pieces of one split request. The stimulus starts a 2048-byte request with a low limit. After the first piece is taken, it raises the limit above the threshold, while downstream ready is throttled so that later pieces stall. The bench then checks that the remaining pieces are still 512 bytes, and that the next request goes out whole. A vector table covers the boundaries around 512 bytes and the 4096-byte zero encoding. It also covers the limit values on each side of the threshold and an address that wraps.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int          BCNT_W      = 12;
  localparam logic [15:0] CAP_UNITS   = 16'h0020;
  localparam logic [15:0] FULL_THRESH = 16'h0100;
  localparam int          CHUNK_BYTES = 512;
endpackage

// File: rtl/srd_cfg_reg.sv
module srd_cfg_reg #(
  parameter logic [15:0] CAP = srd_pkg::CAP_UNITS
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [15:0] limit_o,
  output logic [31:0] rdata_o
);
  logic [15:0] limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   limit_q <= CAP;
    else if (we_i) limit_q <= wdata_i[31:16];
  end

  assign limit_o = limit_q;
  assign rdata_o = {limit_q, CAP};
endmodule

// File: rtl/srd_slicer.sv
module srd_slicer #(
  parameter int BCNT_W = srd_pkg::BCNT_W,
  parameter int CHUNK  = srd_pkg::CHUNK_BYTES,
  localparam int REM_W = BCNT_W + 1
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic              split_i,
  output logic [REM_W-1:0]  size_o,
  output logic [BCNT_W-1:0] bcnt_o,
  output logic              last_o
);
  generate
    if (CHUNK >= (1 << BCNT_W)) begin : g_no_cap
      // chunk covers the largest count; splitting never shortens a piece
      logic unused_split;
      assign unused_split = split_i;
      assign size_o = rem_i;
    end else begin : g_cap
      localparam logic [REM_W-1:0] CHUNK_V = REM_W'(CHUNK);
      always_comb begin
        size_o = rem_i;
        if (split_i && (rem_i > CHUNK_V)) size_o = CHUNK_V;
      end
    end
  endgenerate

  assign bcnt_o = size_o[BCNT_W-1:0];
  assign last_o = (size_o == rem_i);
endmodule

// File: rtl/srd_seq.sv
module srd_seq #(
  parameter int          ADDR_W = 32,
  parameter int          BCNT_W = srd_pkg::BCNT_W,
  parameter logic [15:0] THRESH = srd_pkg::FULL_THRESH,
  localparam int REM_W = BCNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       limit_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BCNT_W-1:0] req_bcnt_i,
  input  logic [REM_W-1:0]  size_i,
  input  logic              last_i,
  input  logic              sub_ready_i,
  output logic              busy_o,
  output logic              split_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REM_W-1:0]  rem_o
);
  localparam logic [REM_W-1:0] MAX_CNT = {1'b1, {BCNT_W{1'b0}}};

  logic              busy_q, split_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic              accept, fire;

  assign accept = req_valid_i && !busy_q;
  assign fire   = busy_q && sub_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      split_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      split_q <= (limit_i < THRESH);
      addr_q  <= req_addr_i;
      rem_q   <= (req_bcnt_i == '0) ? MAX_CNT : {1'b0, req_bcnt_i};
    end else if (fire) begin
      addr_q <= addr_q + ADDR_W'(size_i);
      rem_q  <= rem_q - size_i;
      if (last_i) busy_q <= 1'b0;
    end
  end

  assign req_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign split_o     = split_q;
  assign addr_o      = addr_q;
  assign rem_o       = rem_q;
endmodule

// File: rtl/split_read_decomposer.sv
module split_read_decomposer #(
  parameter int          ADDR_W = 32,
  parameter int          BCNT_W = srd_pkg::BCNT_W,
  parameter int          CHUNK  = srd_pkg::CHUNK_BYTES,
  parameter logic [15:0] CAP    = srd_pkg::CAP_UNITS,
  parameter logic [15:0] THRESH = srd_pkg::FULL_THRESH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BCNT_W-1:0] req_bcnt_i,
  output logic              sub_valid_o,
  input  logic              sub_ready_i,
  output logic [ADDR_W-1:0] sub_addr_o,
  output logic [BCNT_W-1:0] sub_bcnt_o,
  output logic              sub_last_o
);
  localparam int REM_W = BCNT_W + 1;

  logic [15:0]      limit;
  logic [REM_W-1:0] rem, sub_size;
  logic             split_mode, busy, last;

  srd_cfg_reg #(.CAP(CAP)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .limit_o (limit),
    .rdata_o (cfg_rdata_o)
  );

  srd_seq #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .THRESH(THRESH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .limit_i     (limit),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_bcnt_i  (req_bcnt_i),
    .size_i      (sub_size),
    .last_i      (last),
    .sub_ready_i (sub_ready_i),
    .busy_o      (busy),
    .split_o     (split_mode),
    .addr_o      (sub_addr_o),
    .rem_o       (rem)
  );

  srd_slicer #(.BCNT_W(BCNT_W), .CHUNK(CHUNK)) u_slice (
    .rem_i   (rem),
    .split_i (split_mode),
    .size_o  (sub_size),
    .bcnt_o  (sub_bcnt_o),
    .last_o  (last)
  );

  assign sub_valid_o = busy;
  assign sub_last_o  = last;
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int          ADDR_W = 32,
  parameter int          BCNT_W = 12,
  parameter int          CHUNK  = 512,
  parameter logic [15:0] CAP    = 16'h0020,
  localparam int REM_W = BCNT_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [31:0]       cfg_wdata_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              req_ready_o,
  input logic              sub_valid_o,
  input logic              sub_ready_i,
  input logic [ADDR_W-1:0] sub_addr_o,
  input logic [BCNT_W-1:0] sub_bcnt_o,
  input logic              sub_last_o,
  input logic              split_mode,
  input logic [REM_W-1:0]  sub_size
);
  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == {$past(cfg_wdata_i[31:16]), CAP}); // R2

  AST_PIECE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && split_mode |-> sub_size <= REM_W'(CHUNK)); // R3

  AST_FULL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && !split_mode |-> sub_last_o); // R4

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_ready_i && !sub_last_o |=>
      sub_valid_o && sub_addr_o == $past(sub_addr_o) + ADDR_W'($past(sub_size))); // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && !sub_ready_i |=> sub_valid_o && $stable(sub_addr_o)
      && $stable(sub_bcnt_o) && $stable(sub_last_o)); // R8

  AST_BLOCK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> !req_ready_o); // R8
endmodule

bind split_read_decomposer srd_checker #(
  .ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .CHUNK(CHUNK), .CAP(CAP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .req_ready_o (req_ready_o),
  .sub_valid_o (sub_valid_o),
  .sub_ready_i (sub_ready_i),
  .sub_addr_o  (sub_addr_o),
  .sub_bcnt_o  (sub_bcnt_o),
  .sub_last_o  (sub_last_o),
  .split_mode  (split_mode),
  .sub_size    (sub_size)
);

// File: tb/tb_split_read_decomposer.sv
module tb_split_read_decomposer;
  localparam int NV = 9;
  // {limit[59:44], addr[43:12], bcnt[11:0]}
  localparam logic [59:0] VEC [NV] = '{
    {16'h0020, 32'h0000_1000, 12'd0},
    {16'h0020, 32'h0000_2010, 12'd1300},
    {16'h0020, 32'h0000_3000, 12'd512},
    {16'h00FF, 32'h0000_4004, 12'd513},
    {16'h0100, 32'h0000_5000, 12'd3000},
    {16'h0100, 32'h0000_6000, 12'd0},
    {16'hFFFF, 32'h0000_7000, 12'd100},
    {16'h0020, 32'h0000_8000, 12'd1},
    {16'h0080, 32'hFFFF_FE00, 12'd1024}
  };

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_addr = '0;
  logic [11:0] req_bcnt = '0;
  logic        sub_valid, sub_ready = 0, sub_last;
  logic [31:0] sub_addr;
  logic [11:0] sub_bcnt;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] cur_lim = 16'h0020;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  split_read_decomposer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_bcnt_i(req_bcnt),
    .sub_valid_o(sub_valid), .sub_ready_i(sub_ready),
    .sub_addr_o(sub_addr), .sub_bcnt_o(sub_bcnt), .sub_last_o(sub_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_lim(input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    cur_lim = v[31:16];
  endtask

  // Sends one request, collects its pieces against a model.
  // mid_wr: after the first piece, write mid_val to the config word.
  task automatic run_req(input logic [31:0] a, input logic [11:0] b,
                         input bit mid_wr, input logic [31:0] mid_val, input string tag);
    int          rem, size, npieces, exp_n, wr_state;
    logic [31:0] ea;
    bit          split, done, stall_seen;
    logic [31:0] h_addr; logic [11:0] h_bcnt; logic h_last;
    rem = (b == 0) ? 4096 : int'(b);
    split = (cur_lim < 16'h0100);
    exp_n = split ? (rem + 511) / 512 : 1;
    ea = a; npieces = 0; done = 0; wr_state = 0; stall_seen = 0;
    h_addr = '0; h_bcnt = '0; h_last = 0;
    @(negedge clk);
    chk(req_ready == 1, {tag, " R8 idle ready"}, 64'(req_ready), 1);
    req_valid = 1; req_addr = a; req_bcnt = b;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, {tag, " R8 busy blocks req"}, 64'(req_ready), 0);
    while (!done) begin
      if (stall_seen)
        chk(sub_valid && sub_addr == h_addr && sub_bcnt == h_bcnt && sub_last == h_last,
            {tag, " R8 hold"}, {sub_addr, 20'(sub_bcnt), 12'(sub_last)},
            {h_addr, 20'(h_bcnt), 12'(h_last)});
      if (wr_state == 1) begin cfg_we = 1; cfg_wdata = mid_val; wr_state = 2; end
      else if (wr_state == 2) begin cfg_we = 0; cur_lim = mid_val[31:16]; wr_state = 3; end
      sub_ready = (cyc % 3) != 1;
      stall_seen = sub_valid && !sub_ready;
      h_addr = sub_addr; h_bcnt = sub_bcnt; h_last = sub_last;
      if (sub_valid && sub_ready) begin
        size = (split && rem > 512) ? 512 : rem;
        chk(sub_addr == ea && sub_bcnt == 12'(size) && sub_last == (size == rem),
            {tag, " R3 R4 R5 R6 piece"}, {sub_addr, 20'(sub_bcnt), 12'(sub_last)},
            {ea, 20'(12'(size)), 12'(size == rem)});
        ea = ea + 32'(size); rem = rem - size; npieces++;
        if (mid_wr && wr_state == 0) wr_state = 1;
        if (sub_last || npieces > 16) done = 1;
      end
      @(negedge clk);
    end
    sub_ready = 0;
    if (wr_state == 1) begin cfg_we = 1; cfg_wdata = mid_val; @(negedge clk); wr_state = 2; end
    if (wr_state == 2) begin cfg_we = 0; cur_lim = mid_val[31:16]; end
    chk(npieces == exp_n && rem == 0, {tag, " R5 piece count"}, 64'(npieces), 64'(exp_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sub_valid == 0 && req_ready == 1, "R9 in reset", {sub_valid, req_ready}, 2'b01);
    chk(cfg_rdata == 32'h0020_0020, "R1 reset value", cfg_rdata, 32'h0020_0020);
    rst_n = 1;
    @(negedge clk);
    chk(sub_valid == 0 && req_ready == 1, "R9 after reset", {sub_valid, req_ready}, 2'b01);

    write_lim(32'hABCD_1234);
    chk(cfg_rdata == 32'hABCD_0020, "R2 low half ignored", cfg_rdata, 32'hABCD_0020);
    write_lim(32'h0020_FFFF);
    chk(cfg_rdata == 32'h0020_0020, "R1 R2 readback", cfg_rdata, 32'h0020_0020);

    for (int i = 0; i < NV; i++) begin
      write_lim({VEC[i][59:44], 16'h0000});
      run_req(VEC[i][43:12], VEC[i][11:0], 0, '0, $sformatf("vec%0d", i));
    end

    // R7: limit raised during a split
    write_lim(32'h0020_0000);
    run_req(32'h0001_0000, 12'd2048, 1, 32'h0100_0000, "R7 mid write");
    chk(cfg_rdata == 32'h0100_0020, "R7 limit updated", cfg_rdata, 32'h0100_0020);
    run_req(32'h0002_0000, 12'd2048, 0, '0, "R7 next whole");
    // R7: limit lowered during a whole transfer has no effect on it
    run_req(32'h0003_0000, 12'd0, 1, 32'h0020_0000, "R7 lower mid");
    run_req(32'h0004_0000, 12'd2048, 0, '0, "R7 next split");

    // R9: reset mid-split
    run_req(32'h0005_0000, 12'd1024, 0, '0, "R6 pre");
    @(negedge clk); req_valid = 1; req_addr = 32'h9000; req_bcnt = 12'd2048;
    @(negedge clk); req_valid = 0;
    rst_n = 0;
    @(negedge clk);
    chk(sub_valid == 0 && req_ready == 1 && cfg_rdata == 32'h0020_0020,
        "R9 R1 reset mid split", {sub_valid, req_ready, cfg_rdata}, {2'b01, 32'h0020_0020});
    rst_n = 1; cur_lim = 16'h0020;
    run_req(32'h000A_0000, 12'd600, 0, '0, "R9 post reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule